// File: doc/BRIEF.md
# Strobed Bidirectional Port Handshake

This block is an 8-bit peripheral port that sends and receives over one shared data bus. Data the CPU writes is held in an outbound latch. A full flag, which is active low, tells the peripheral that data is waiting. When the peripheral pulls its acknowledge low, the latched byte is driven onto the bus through a tri-state enable. At all other times the bus is released. In the other direction, the peripheral holds its strobe low to capture the bus into an inbound latch. A full flag then tells the CPU that a byte is waiting, and the flag clears when the CPU finishes reading it.

A single active-high interrupt request covers both directions. Each direction has its own interrupt-enable flag. The CPU sets or clears a flag with a bit set/reset command that names a control-port bit number: bit 4 selects the inbound enable and bit 6 selects the outbound enable. All strobes are active low and are assumed to be synchronous to the block clock. Edges are detected against the value registered on the previous clock.

Top module: `bsp_port`

## Requirements
- R1: While rst_n is low at a clock edge, the next state is: out_full_n high, in_full low, irq low, and both interrupt enables clear.
- R2: A falling edge of cpu_wr_n stores cpu_wdata in the outbound latch, and out_full_n is low from the following clock.
- R3: bus_oe is high exactly while periph_ack_n is low, and while it is high bus_out equals the outbound latch. While periph_ack_n is high, bus_oe is low.
- R4: A falling edge of periph_ack_n returns out_full_n high on the following clock.
- R5: While periph_stb_n is low, bus_in is captured into the inbound latch at every clock. in_full is high from the following clock, and cpu_rdata shows the latch.
- R6: A rising edge of cpu_rd_n clears in_full on the following clock, and cpu_rdata keeps its value.
- R7: A rising edge of periph_ack_n, seen while out_full_n is high and the outbound enable is set, raises irq on the following clock. A falling edge of cpu_wr_n clears that request.
- R8: A rising edge of periph_stb_n, seen while in_full is high and the inbound enable is set, raises irq on the following clock. A falling edge of cpu_rd_n clears that request.
- R9: A pulse on bsr_wr with bsr_bit = 4 or 6 sets the addressed enable when bsr_set = 1 and clears it when bsr_set = 0. Any other bit number has no effect. Clearing an enable masks its pending request from irq. A handshake seen while its enable is clear raises no request.
- R10: Once periph_stb_n is high, the inbound latch holds its value whatever bus_in does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr_n | input | 1 | CPU data write strobe, active low |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd_n | input | 1 | CPU data read strobe, active low |
| cpu_rdata | output | 8 | Inbound latch contents |
| bsr_wr | input | 1 | Bit set/reset command pulse |
| bsr_bit | input | 3 | Control-port bit number addressed by the command |
| bsr_set | input | 1 | 1 sets, 0 clears the addressed bit |
| periph_stb_n | input | 1 | Peripheral strobe, active low, loads inbound latch |
| periph_ack_n | input | 1 | Peripheral acknowledge, active low, enables bus driver |
| bus_in | input | 8 | Bus value seen at the pins |
| bus_out | output | 8 | Value driven onto the bus when enabled |
| bus_oe | output | 1 | Tri-state driver enable |
| out_full_n | output | 1 | Outbound latch full, active low |
| in_full | output | 1 | Inbound latch full |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches every cycle to confirm that each flag moves only for its own cause. The outbound full flag falls only after a write edge and rises only after an acknowledge edge. The inbound full flag rises only under a low strobe and falls only after a read edge. A new interrupt appears only after an acknowledge or strobe rising edge, or after an enable command. Data values need the bench's scenarios to be shown: what the driver puts out, what the inbound latch captures and keeps, and the decoding of bit numbers. The same holds for masking by a cleared enable and for clearing requests through reads and writes.

// File: rtl/bsp_pkg.sv
// Package bsp_pkg: types and constants shared by the port handshake block.
// Assumes every strobe is active low and synchronous to the block clock.
package bsp_pkg;
    // One detected transition on a strobe line.
    typedef struct packed {
        logic fall;
        logic rise;
    } bsp_edge_t;

    // Indices of the strobe lines in the top module's edge detector array.
    localparam int unsigned STB_WR   = 0;
    localparam int unsigned STB_RD   = 1;
    localparam int unsigned STB_ACK  = 2;
    localparam int unsigned STB_PSTB = 3;
    localparam int unsigned NUM_STB  = 4;
endpackage

// File: rtl/bsp_edge_det.sv
// Module bsp_edge_det: registers one strobe and reports its falling and
// rising edges, compared against the value at the previous clock.
// Assumes the input is synchronous and idles at IDLE_LVL, which is also
// the value loaded during reset so no edge is reported right after reset.
module bsp_edge_det
    import bsp_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig,
    output bsp_edge_t ev
);
    logic prev_q;

    // Remember the level sampled at the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE_LVL;
        else        prev_q <= sig;
    end

    // Compare current level with the remembered one.
    always_comb begin
        ev.fall = prev_q & ~sig;
        ev.rise = ~prev_q & sig;
    end
endmodule

// File: rtl/bsp_out_chan.sv
// Module bsp_out_chan: outbound half of the port. Holds the CPU write data,
// keeps the active-low full flag, drives the bus while acknowledge is low,
// and keeps the outbound interrupt request.
// Assumes edge inputs are single-cycle pulses from bsp_edge_det.
module bsp_out_chan #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_fall,
    input  logic [DW-1:0] wdata,
    input  logic          ack_n,
    input  logic          ack_fall,
    input  logic          ack_rise,
    input  logic          en,
    output logic [DW-1:0] drv_data,
    output logic          drv_oe,
    output logic          full_n,
    output logic          req
);
    logic [DW-1:0] data_q;
    logic          full_n_q;
    logic          req_q;

    // Load the outbound latch on a CPU write edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (wr_fall) data_q <= wdata;
    end

    // Full flag: low after a write, high again once the peripheral acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n)        full_n_q <= 1'b1;
        else if (wr_fall)  full_n_q <= 1'b0;
        else if (ack_fall) full_n_q <= 1'b1;
    end

    // Request: raised at the end of an acknowledge, dropped by the next write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          req_q <= 1'b0;
        else if (ack_rise && full_n_q && en) req_q <= 1'b1;
        else if (wr_fall)                    req_q <= 1'b0;
    end

    // The driver is enabled only while acknowledge is held low.
    always_comb begin
        drv_oe   = ~ack_n;
        drv_data = data_q;
        full_n   = full_n_q;
        req      = req_q;
    end
endmodule

// File: rtl/bsp_in_chan.sv
// Module bsp_in_chan: inbound half of the port. Captures the bus while the
// peripheral strobe is low, keeps the full flag for the CPU, and keeps the
// inbound interrupt request.
// Assumes edge inputs are single-cycle pulses from bsp_edge_det.
module bsp_in_chan #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_n,
    input  logic          stb_rise,
    input  logic          rd_fall,
    input  logic          rd_rise,
    input  logic [DW-1:0] bus_data,
    input  logic          en,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          req
);
    logic [DW-1:0] data_q;
    logic          full_q;
    logic          req_q;

    // Capture the bus on every clock the strobe is held low.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (!stb_n) data_q <= bus_data;
    end

    // Full flag: set by a low strobe, cleared when the CPU read ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       full_q <= 1'b0;
        else if (!stb_n)  full_q <= 1'b1;
        else if (rd_rise) full_q <= 1'b0;
    end

    // Request: raised at the end of a strobe, dropped when a read starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                        req_q <= 1'b0;
        else if (stb_rise && full_q && en) req_q <= 1'b1;
        else if (rd_fall)                  req_q <= 1'b0;
    end

    // Present latch and flags.
    always_comb begin
        rdata = data_q;
        full  = full_q;
        req   = req_q;
    end
endmodule

// File: rtl/bsp_enable_ctl.sv
// Module bsp_enable_ctl: the two interrupt-enable flags, written by bit
// set/reset commands that address a control-port bit number.
// Assumes bsr_wr is a single-cycle command pulse.
module bsp_enable_ctl #(
    parameter int unsigned BIT_W   = 3,
    parameter int unsigned IN_BIT  = 4,
    parameter int unsigned OUT_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bsr_wr,
    input  logic [BIT_W-1:0] bsr_bit,
    input  logic             bsr_set,
    output logic             en_in,
    output logic             en_out
);
    localparam int unsigned NFLAG = 2;
    localparam logic [BIT_W-1:0] SEL [NFLAG] = '{BIT_W'(IN_BIT), BIT_W'(OUT_BIT)};

    logic [NFLAG-1:0] flag_q;

    // One flag per addressable bit number.
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        // Update this flag only when the command names its bit.
        always_ff @(posedge clk) begin
            if (!rst_n)                          flag_q[g] <= 1'b0;
            else if (bsr_wr && bsr_bit == SEL[g]) flag_q[g] <= bsr_set;
        end
    end

    // Map flags to named outputs.
    always_comb begin
        en_in  = flag_q[0];
        en_out = flag_q[1];
    end
endmodule

// File: rtl/bsp_port.sv
// Module bsp_port: top of the strobed bidirectional port. Detects edges on
// the four strobes, runs the outbound and inbound channels, holds the
// enables, and merges both masked requests into one interrupt.
// Assumes all strobes are synchronous to clk; the pad-level tri-state
// buffer is built outside from bus_out and bus_oe.
module bsp_port
    import bsp_pkg::*;
#(
    parameter int unsigned DW      = 8,
    parameter int unsigned BIT_W   = 3,
    parameter int unsigned IN_BIT  = 4,
    parameter int unsigned OUT_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr_n,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic             cpu_rd_n,
    output logic [DW-1:0]    cpu_rdata,
    input  logic             bsr_wr,
    input  logic [BIT_W-1:0] bsr_bit,
    input  logic             bsr_set,
    input  logic             periph_stb_n,
    input  logic             periph_ack_n,
    input  logic [DW-1:0]    bus_in,
    output logic [DW-1:0]    bus_out,
    output logic             bus_oe,
    output logic             out_full_n,
    output logic             in_full,
    output logic             irq
);
    logic [NUM_STB-1:0] stb_lvl;
    bsp_edge_t          ev [NUM_STB];
    logic               en_in, en_out, req_in, req_out;

    // Gather strobe levels for the detector array.
    always_comb begin
        stb_lvl[STB_WR]   = cpu_wr_n;
        stb_lvl[STB_RD]   = cpu_rd_n;
        stb_lvl[STB_ACK]  = periph_ack_n;
        stb_lvl[STB_PSTB] = periph_stb_n;
    end

    for (genvar s = 0; s < NUM_STB; s++) begin : g_edge
        bsp_edge_det #(.IDLE_LVL(1'b1)) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .sig   (stb_lvl[s]),
            .ev    (ev[s])
        );
    end

    bsp_enable_ctl #(.BIT_W(BIT_W), .IN_BIT(IN_BIT), .OUT_BIT(OUT_BIT)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .bsr_wr  (bsr_wr),
        .bsr_bit (bsr_bit),
        .bsr_set (bsr_set),
        .en_in   (en_in),
        .en_out  (en_out)
    );

    bsp_out_chan #(.DW(DW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fall  (ev[STB_WR].fall),
        .wdata    (cpu_wdata),
        .ack_n    (periph_ack_n),
        .ack_fall (ev[STB_ACK].fall),
        .ack_rise (ev[STB_ACK].rise),
        .en       (en_out),
        .drv_data (bus_out),
        .drv_oe   (bus_oe),
        .full_n   (out_full_n),
        .req      (req_out)
    );

    bsp_in_chan #(.DW(DW)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_n    (periph_stb_n),
        .stb_rise (ev[STB_PSTB].rise),
        .rd_fall  (ev[STB_RD].fall),
        .rd_rise  (ev[STB_RD].rise),
        .bus_data (bus_in),
        .en       (en_in),
        .rdata    (cpu_rdata),
        .full     (in_full),
        .req      (req_in)
    );

    // Merge both requests, each masked by its own enable.
    always_comb begin
        irq = (req_out & en_out) | (req_in & en_in);
    end
endmodule

// File: rtl/bsp_port_checker.sv
// Module bsp_port_checker: cycle-by-cycle properties on the ports of
// bsp_port, attached through a bind. Assumes reset is held at least two
// clocks with all strobes high.
module bsp_port_checker #(
    parameter int unsigned BIT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_wr_n,
    input logic             cpu_rd_n,
    input logic             bsr_wr,
    input logic             periph_stb_n,
    input logic             periph_ack_n,
    input logic             out_full_n,
    input logic             in_full,
    input logic             irq
);
    // R1: reset puts the flags in their idle state.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (out_full_n && !in_full && !irq));

    // R2: the outbound flag falls only after a write falling edge.
    p_obf_fall_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_full_n) |-> (!$past(cpu_wr_n) && $past(cpu_wr_n, 2)));

    // R4: the outbound flag rises only after an acknowledge falling edge.
    p_obf_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_full_n) |-> (!$past(periph_ack_n) && $past(periph_ack_n, 2)));

    // R5: the inbound flag rises only under a low strobe.
    p_ibf_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_full) |-> !$past(periph_stb_n));

    // R6: the inbound flag falls only after a read rising edge.
    p_ibf_fall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_full) |-> ($past(cpu_rd_n) && !$past(cpu_rd_n, 2)));

    // R7, R8, R9: a new interrupt needs a handshake end or an enable command.
    p_irq_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (($past(periph_ack_n) && !$past(periph_ack_n, 2)) ||
                        ($past(periph_stb_n) && !$past(periph_stb_n, 2)) ||
                        $past(bsr_wr)));
endmodule

bind bsp_port bsp_port_checker #(.BIT_W(BIT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wr_n     (cpu_wr_n),
    .cpu_rd_n     (cpu_rd_n),
    .bsr_wr       (bsr_wr),
    .periph_stb_n (periph_stb_n),
    .periph_ack_n (periph_ack_n),
    .out_full_n   (out_full_n),
    .in_full      (in_full),
    .irq          (irq)
);

// File: tb/bsp_port_tb_top.sv
// Directed bench for bsp_port: one task per scenario, each checking itself.
module bsp_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_n = 1'b1, cpu_rd_n = 1'b1;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic       bsr_wr = 1'b0, bsr_set = 1'b0;
    logic [2:0] bsr_bit = '0;
    logic       periph_stb_n = 1'b1, periph_ack_n = 1'b1;
    logic [7:0] bus_in = '0, bus_out;
    logic       bus_oe, out_full_n, in_full, irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bsp_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata),
        .cpu_rd_n(cpu_rd_n), .cpu_rdata(cpu_rdata),
        .bsr_wr(bsr_wr), .bsr_bit(bsr_bit), .bsr_set(bsr_set),
        .periph_stb_n(periph_stb_n), .periph_ack_n(periph_ack_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .out_full_n(out_full_n), .in_full(in_full), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bsr(input logic [2:0] b, input logic s);
        bsr_bit = b; bsr_set = s; bsr_wr = 1'b1;
        tick();
        bsr_wr = 1'b0;
        tick();
    endtask

    task automatic cpu_write(input logic [7:0] d);
        cpu_wdata = d; cpu_wr_n = 1'b0;
        tick();
        check("R2 obf low", {7'b0, out_full_n}, 8'h0);
        cpu_wr_n = 1'b1;
        tick();
    endtask

    task automatic cpu_read();
        cpu_rd_n = 1'b0;
        tick();
        cpu_rd_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        check("R1 obf", {7'b0, out_full_n}, 8'h1);
        check("R1 ibf", {7'b0, in_full}, 8'h0);
        check("R1 irq", {7'b0, irq}, 8'h0);
        check("R1 oe", {7'b0, bus_oe}, 8'h0);
    endtask

    task automatic t_output(input logic [7:0] d);
        bsr(3'd6, 1'b1);
        cpu_write(d);
        check("R3 oe off while ack high", {7'b0, bus_oe}, 8'h0);
        periph_ack_n = 1'b0;
        #1;
        check("R3 oe on", {7'b0, bus_oe}, 8'h1);
        check("R3 bus data", bus_out, d);
        tick();
        check("R4 obf high", {7'b0, out_full_n}, 8'h1);
        check("R7 no irq yet", {7'b0, irq}, 8'h0);
        periph_ack_n = 1'b1;
        #1;
        check("R3 oe released", {7'b0, bus_oe}, 8'h0);
        tick();
        check("R7 irq on ack end", {7'b0, irq}, 8'h1);
        cpu_wr_n = 1'b0; cpu_wdata = ~d;
        tick();
        check("R7 irq cleared by write", {7'b0, irq}, 8'h0);
        cpu_wr_n = 1'b1;
        tick();
        periph_ack_n = 1'b0; tick(); periph_ack_n = 1'b1; tick();
        bsr(3'd6, 1'b0);
    endtask

    task automatic t_input(input logic [7:0] a, input logic [7:0] b);
        bsr(3'd4, 1'b1);
        bus_in = a; periph_stb_n = 1'b0;
        tick();
        check("R5 ibf set", {7'b0, in_full}, 8'h1);
        check("R5 data a", cpu_rdata, a);
        bus_in = b;
        tick();
        check("R5 data follows strobe", cpu_rdata, b);
        periph_stb_n = 1'b1;
        tick();
        check("R8 irq on strobe end", {7'b0, irq}, 8'h1);
        bus_in = ~b;
        tick();
        check("R10 latch holds", cpu_rdata, b);
        cpu_rd_n = 1'b0;
        tick();
        check("R8 irq cleared by read", {7'b0, irq}, 8'h0);
        check("R6 ibf held during read", {7'b0, in_full}, 8'h1);
        cpu_rd_n = 1'b1;
        tick();
        check("R6 ibf cleared", {7'b0, in_full}, 8'h0);
        check("R6 data kept", cpu_rdata, b);
        bsr(3'd4, 1'b0);
    endtask

    task automatic t_enables();
        // Enable clear: strobe end raises nothing.
        bus_in = 8'h3C; periph_stb_n = 1'b0; tick();
        periph_stb_n = 1'b1; tick();
        check("R9 no irq when disabled", {7'b0, irq}, 8'h0);
        // Other bit numbers have no effect.
        for (int k = 0; k < 8; k++) begin
            if (k != 4 && k != 6) bsr(3'(k), 1'b1);
        end
        check("R9 other bits ignored", {7'b0, irq}, 8'h0);
        cpu_read();
        // Enable, raise, then mask by clearing.
        bsr(3'd4, 1'b1);
        periph_stb_n = 1'b0; tick();
        periph_stb_n = 1'b1; tick();
        check("R9 irq with enable", {7'b0, irq}, 8'h1);
        bsr(3'd4, 1'b0);
        check("R9 irq masked", {7'b0, irq}, 8'h0);
        bsr(3'd4, 1'b1);
        check("R9 irq unmasked", {7'b0, irq}, 8'h1);
        cpu_read();
        check("R8 cleared after read", {7'b0, irq}, 8'h0);
        bsr(3'd4, 1'b0);
    endtask

    task automatic t_reset_mid();
        bsr(3'd6, 1'b1);
        cpu_write(8'h77);
        periph_stb_n = 1'b0; tick(); periph_stb_n = 1'b1;
        rst_n = 1'b0; tick(); tick();
        rst_n = 1'b1; tick();
        check("R1 obf after reset", {7'b0, out_full_n}, 8'h1);
        check("R1 ibf after reset", {7'b0, in_full}, 8'h0);
        // Enable was cleared by reset: ack end raises nothing.
        periph_ack_n = 1'b0; tick(); periph_ack_n = 1'b1; tick();
        check("R1 enable cleared", {7'b0, irq}, 8'h0);
    endtask

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_output(8'hA5);
        t_output(8'h5A);
        t_input(8'h81, 8'h42);
        t_input(8'hFF, 8'h00);
        t_enables();
        t_reset_mid();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule